// File: doc/BRIEF.md
# Memory Write Protection Unit

This block guards every write that reaches a 512-byte nonvolatile memory and its configuration byte. It sits behind a serial command decoder and receives one-cycle strobes: arm the write latch, disarm it, write the configuration byte, read the configuration byte, load a byte address, and write one memory byte. For each write strobe it answers in the same cycle with a grant or a refusal. It also keeps the byte address that the decoder advances after every data byte.

Three layers of protection are combined. The first is a software write latch that a dedicated command must arm before any write. The second is a protected window at the top of the array that covers the upper quarter, the upper half or the whole array. The third is an active-low protect pin that the configuration byte can make binding. The latch disarms itself at the end of any transaction that carried a write. The decoder marks that end with a one-cycle pulse when chip select rises.

Configuration byte layout: bit 7 makes the pin binding, bits 3:2 select the window, bit 1 mirrors the write latch and is read-only, and bits 6:4 and bit 0 read as zero.

Top module: `wr_guard`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the write latch, the pin-binding bit, the window code and the byte address are all zero, so status_byte reads 0x00.
- R2: A cmd_wren strobe sets the write latch (status_byte bit 1 = 1) from the next cycle on. A cmd_wrdi strobe clears it from the next cycle on.
- R3: mem_we and sr_we are asserted in the cycle of their strobe only while the write latch is set.
- R4: Window codes in bits 3:2: 00 protects nothing, 01 protects addresses 0x180-0x1FF, 10 protects 0x100-0x1FF, 11 protects all addresses. A memory write to a protected address is refused.
- R5: While bit 7 is 1 and wp_n is 0, every memory write and every status write is refused.
- R6: While bit 7 is 0, the level of wp_n has no effect on any grant.
- R7: A granted status write stores sr_wdata bit 7 and bits 3:2 from the next cycle on. The other written bits are ignored. A refused status write leaves the configuration byte unchanged.
- R8: A cs_end pulse clears the write latch when the transaction carried at least one memory or status write strobe (granted or not), counting a strobe in the cs_end cycle itself. A transaction with no write strobe leaves the latch as it was.
- R9: addr_load loads addr_in into mem_addr for the next cycle and takes priority over mem_wr. Each mem_wr strobe advances the address by one, whether the write is granted or refused, and 0x1FF wraps to 0x000.
- R10: One cycle after a cmd_rdsr strobe, sr_rd_valid is 1 and sr_rd_data holds the status byte as it was in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Active-low protect pin |
| cs_end | input | 1 | Pulse: chip select went inactive, transaction over |
| cmd_wren | input | 1 | Strobe: arm write latch |
| cmd_wrdi | input | 1 | Strobe: disarm write latch |
| cmd_wrsr | input | 1 | Strobe: write configuration byte |
| cmd_rdsr | input | 1 | Strobe: read configuration byte |
| sr_wdata | input | 8 | Byte offered with cmd_wrsr |
| addr_load | input | 1 | Strobe: load starting byte address |
| addr_in | input | 9 | Starting byte address |
| mem_wr | input | 1 | Strobe: one memory data byte to write |
| mem_addr | output | 9 | Current byte address |
| mem_we | output | 1 | Memory write granted this cycle |
| sr_we | output | 1 | Status write granted this cycle |
| status_byte | output | 8 | Live configuration byte |
| sr_rd_valid | output | 1 | Registered read response valid |
| sr_rd_data | output | 8 | Registered read response byte |

## Verification
Memory writes are issued with the latch clear, the latch set, and around both edges of each window (0x17F against 0x180, 0x0FF against 0x100, and 0x000 under full protection). These runs separate the latch check from the window check. The pin is driven low with binding on and with binding off, which tells a pin that protects only when enabled from one that always protects or never does. Transactions with a refused write, with only a read, and with a write strobe in the cs_end cycle itself show when the latch clears. An address wrap from 0x1FF, including over refused writes, shows that the address advances apart from the grant.

// File: rtl/wg_pkg.sv
// Package: shared widths, status layout and window codes for the write guard.
// Assumes a byte-wide status register and an array addressed by ADDR_W bits.
package wg_pkg;
    localparam int STAT_W = 8;

    // Window codes held in status bits 3:2.
    typedef enum logic [1:0] {
        WIN_NONE    = 2'b00,
        WIN_QUARTER = 2'b01,
        WIN_HALF    = 2'b10,
        WIN_ALL     = 2'b11
    } win_code_e;

    // Writable protection state.
    typedef struct packed {
        logic      pin_bind;
        win_code_e win;
    } prot_cfg_t;

    // Assemble the readable status byte from its parts.
    function automatic logic [STAT_W-1:0] pack_status(input prot_cfg_t cfg, input logic latch);
        pack_status = {cfg.pin_bind, 3'b000, cfg.win, latch, 1'b0};
    endfunction
endpackage

// File: rtl/wg_latch.sv
// Module: software write latch.
// Sets on an arm strobe, clears on a disarm strobe, and clears at transaction
// end when any write strobe was seen since the previous transaction end.
// Assumes command strobes are single-cycle and mutually exclusive.
module wg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    input  logic wr_seen,
    input  logic xact_end,
    output logic latch
);
    logic pend_q;

    // Remember that the open transaction carried a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (xact_end) pend_q <= 1'b0;
        else if (wr_seen)  pend_q <= 1'b1;
    end

    // Latch state: auto-clear first, then disarm, then arm.
    always_ff @(posedge clk) begin
        if (!rst_n)                             latch <= 1'b0;
        else if (xact_end && (pend_q || wr_seen)) latch <= 1'b0;
        else if (disarm)                        latch <= 1'b0;
        else if (arm)                           latch <= 1'b1;
    end

    // R8
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_end && wr_seen) |=> !latch);
    // R2
    wel_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !disarm && !xact_end) |=> latch);
    // R2
    wel_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> !latch);
endmodule

// File: rtl/wg_status.sv
// Module: writable protection fields of the status register.
// Captures the pin-binding bit and window code on a granted write only.
// Assumes the grant is already qualified by latch and pin.
module wg_status
    import wg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_grant,
    input  logic [STAT_W-1:0] wdata,
    output prot_cfg_t         cfg
);
    // Hold or update the protection fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.pin_bind <= 1'b0;
            cfg.win      <= WIN_NONE;
        end else if (wr_grant) begin
            cfg.pin_bind <= wdata[7];
            cfg.win      <= win_code_e'(wdata[3:2]);
        end
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_grant |=> $stable(cfg));
    // R7
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |=> (cfg.pin_bind == $past(wdata[7])) && (cfg.win == $past(wdata[3:2])));
endmodule

// File: rtl/wg_window.sv
// Module: protected-window decoder.
// Flags an address that lies inside the window picked by the code.
// Assumes ADDR_W >= 2 so that the top two bits split the array in quarters.
module wg_window
    import wg_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  win_code_e         win,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TOP = ADDR_W - 1;

    // Compare the top address bits against the selected window.
    always_comb begin
        unique case (win)
            WIN_NONE:    hit = 1'b0;
            WIN_QUARTER: hit = addr[TOP] & addr[TOP-1];
            WIN_HALF:    hit = addr[TOP];
            default:     hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/wg_addr.sv
// Module: byte address counter.
// Loads a start address, then advances on each data byte strobe with wrap.
// Assumes a load and a step in the same cycle resolve in favour of the load.
module wg_addr #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    // Advance or reload the address.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= load_val;
        else if (step) addr <= addr + 1'b1;
    end

    // R9
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && addr == LAST) |=> (addr == '0));
    // R9
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr == $past(load_val)));
endmodule

// File: rtl/wr_guard.sv
// Module: write protection unit (top).
// Combines the write latch, the protected window and the protect pin into
// same-cycle grants for memory and status writes, keeps the byte address and
// answers status reads one cycle after the strobe.
// Assumes at most one command strobe per cycle from the upstream decoder.
module wr_guard
    import wg_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cs_end,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_rdsr,
    input  logic [STAT_W-1:0] sr_wdata,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              sr_we,
    output logic [STAT_W-1:0] status_byte,
    output logic              sr_rd_valid,
    output logic [STAT_W-1:0] sr_rd_data
);
    logic      latch;
    prot_cfg_t cfg;
    logic      win_hit;
    logic      pin_block;

    wg_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (cmd_wren),
        .disarm   (cmd_wrdi),
        .wr_seen  (mem_wr | cmd_wrsr),
        .xact_end (cs_end),
        .latch    (latch)
    );

    wg_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_grant (sr_we),
        .wdata    (sr_wdata),
        .cfg      (cfg)
    );

    wg_window #(.ADDR_W(ADDR_W)) u_window (
        .win  (cfg.win),
        .addr (mem_addr),
        .hit  (win_hit)
    );

    wg_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (addr_in),
        .step     (mem_wr),
        .addr     (mem_addr)
    );

    // Pin protection applies only when the status byte makes it binding.
    always_comb pin_block = cfg.pin_bind & ~wp_n;

    // Same-cycle grants from the three protection layers.
    always_comb begin
        sr_we  = cmd_wrsr & latch & ~pin_block;
        mem_we = mem_wr & latch & ~pin_block & ~win_hit;
    end

    // Live status view.
    always_comb status_byte = pack_status(cfg, latch);

    // Registered status read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_rd_valid <= 1'b0;
            sr_rd_data  <= '0;
        end else begin
            sr_rd_valid <= cmd_rdsr;
            if (cmd_rdsr) sr_rd_data <= status_byte;
        end
    end

    // R3
    mem_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || sr_we) |-> latch);
    // R4
    all_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.win == WIN_ALL) |-> !mem_we);
    // R5
    pin_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.pin_bind && !wp_n) |-> (!mem_we && !sr_we));
    // R10
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdsr |=> (sr_rd_valid && sr_rd_data == $past(status_byte)));
endmodule

// File: tb/wr_guard_bench.sv
// Bench: behavioural model of the protection rules, compared every cycle.
module wr_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_n = 1'b1, cs_end = 1'b0;
    logic       cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_rdsr = 1'b0;
    logic [7:0] sr_wdata = 8'h00;
    logic       addr_load = 1'b0;
    logic [8:0] addr_in = 9'h000;
    logic       mem_wr = 1'b0;
    logic [8:0] mem_addr;
    logic       mem_we, sr_we, sr_rd_valid;
    logic [7:0] status_byte, sr_rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    int m_wel = 0, m_bind = 0, m_win = 0, m_addr = 0, m_pend = 0;
    int m_rdv = 0, m_rdd = 0;

    wr_guard u_wr_guard (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cs_end(cs_end),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_rdsr(cmd_rdsr), .sr_wdata(sr_wdata), .addr_load(addr_load),
        .addr_in(addr_in), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_we(mem_we), .sr_we(sr_we), .status_byte(status_byte),
        .sr_rd_valid(sr_rd_valid), .sr_rd_data(sr_rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int m_status();
        return m_bind * 128 + m_win * 4 + m_wel * 2;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Compare outputs for the stimulus set now, then advance model and clock.
    task automatic tick(input string tag);
        int pinb, inwin, e_srwe, e_memwe;
        #1;
        pinb    = (m_bind == 1 && wp_n == 1'b0) ? 1 : 0;
        case (m_win)
            0: inwin = 0;
            1: inwin = (m_addr >= 384) ? 1 : 0;
            2: inwin = (m_addr >= 256) ? 1 : 0;
            default: inwin = 1;
        endcase
        e_srwe  = (cmd_wrsr && m_wel == 1 && pinb == 0) ? 1 : 0;
        e_memwe = (mem_wr && m_wel == 1 && pinb == 0 && inwin == 0) ? 1 : 0;
        if (rst_n) begin
            chk(tag, "mem_we", int'(mem_we), e_memwe);
            chk(tag, "sr_we", int'(sr_we), e_srwe);
            chk(tag, "mem_addr", int'(mem_addr), m_addr);
            chk(tag, "status_byte", int'(status_byte), m_status());
            chk(tag, "sr_rd_valid", int'(sr_rd_valid), m_rdv);
            if (m_rdv == 1) chk(tag, "sr_rd_data", int'(sr_rd_data), m_rdd);
        end
        if (!rst_n) begin
            m_wel = 0; m_bind = 0; m_win = 0; m_addr = 0; m_pend = 0; m_rdv = 0; m_rdd = 0;
        end else begin
            m_rdv = cmd_rdsr ? 1 : 0;
            if (cmd_rdsr) m_rdd = m_status();
            if (cs_end && (m_pend == 1 || mem_wr || cmd_wrsr)) m_wel = 0;
            else if (cmd_wrdi) m_wel = 0;
            else if (cmd_wren) m_wel = 1;
            if (cs_end) m_pend = 0;
            else if (mem_wr || cmd_wrsr) m_pend = 1;
            if (e_srwe == 1) begin
                m_bind = int'(sr_wdata[7]);
                m_win  = int'(sr_wdata[3:2]);
            end
            if (addr_load) m_addr = int'(addr_in);
            else if (mem_wr) m_addr = (m_addr + 1) % 512;
        end
        @(posedge clk);
        @(negedge clk);
        cs_end = 0; cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_rdsr = 0;
        addr_load = 0; mem_wr = 0;
    endtask

    task automatic wren(input string tag);
        cmd_wren = 1; tick(tag);
    endtask
    task automatic endx(input string tag);
        cs_end = 1; tick(tag);
    endtask
    task automatic wrsr(input string tag, input logic [7:0] d);
        wren(tag); cmd_wrsr = 1; sr_wdata = d; tick(tag); endx(tag);
    endtask
    task automatic memw(input string tag, input logic [8:0] a, input int n);
        wren(tag); addr_load = 1; addr_in = a; tick(tag);
        for (int i = 0; i < n; i++) begin mem_wr = 1; tick(tag); end
        endx(tag);
    endtask

    initial begin
        @(negedge clk);
        tick("R1"); tick("R1");
        rst_n = 1;
        tick("R1");                        // reset state
        cmd_rdsr = 1; tick("R10");         // read 0x00
        tick("R10");
        // refused writes without latch; address still moves
        addr_load = 1; addr_in = 9'h010; tick("R9");
        mem_wr = 1; tick("R3"); mem_wr = 1; tick("R3");
        cmd_wrsr = 1; sr_wdata = 8'h8C; tick("R3");
        endx("R3");
        // arm / disarm
        wren("R2"); cmd_rdsr = 1; tick("R10"); tick("R10");
        cmd_wrdi = 1; tick("R2"); tick("R2");
        // read-only transaction keeps latch
        wren("R8"); cmd_rdsr = 1; tick("R8"); endx("R8"); tick("R8");
        cmd_wrdi = 1; tick("R2");
        // granted writes, no window
        memw("R3", 9'h1FE, 3);             // wraps too
        memw("R9", 9'h1FF, 2);
        // window quarter
        wrsr("R7", 8'h74);                 // only bits 3:2 kept -> 0x04
        cmd_rdsr = 1; tick("R7"); tick("R7");
        memw("R4", 9'h17E, 3);
        // window half
        wrsr("R4", 8'h08);
        memw("R4", 9'h0FE, 3);
        // window all
        wrsr("R4", 8'h0C);
        memw("R4", 9'h000, 2);
        memw("R4", 9'h1FF, 2);             // refused across wrap
        // pin with binding off
        wrsr("R6", 8'h00);
        wp_n = 0;
        memw("R6", 9'h050, 2);
        wrsr("R6", 8'h84);                 // binding set while pin low (allowed)
        memw("R5", 9'h020, 2);             // blocked by pin
        wrsr("R5", 8'h00);                 // refused, config stays 0x84
        cmd_rdsr = 1; tick("R5"); tick("R5");
        wp_n = 1;
        memw("R5", 9'h020, 1);             // allowed again, outside window
        // write strobe in the cs_end cycle itself
        wren("R8"); addr_load = 1; addr_in = 9'h030; tick("R8");
        mem_wr = 1; cs_end = 1; tick("R8"); tick("R8");
        // reset again mid-state
        wren("R1"); rst_n = 0; tick("R1"); rst_n = 1; tick("R1");
        tick("R1");
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule